// File: doc/BRIEF.md
# Round-Robin Readout Concentrator

This block collects hit words from many small per-channel-group FIFOs and merges them into one deep master FIFO for a readout chip. The controller runs on a fast clock that is a fixed multiple of the frame rate. Eight fast slots make up one frame. The local FIFOs are grouped into banks of eight. Within a frame, each slot serves the next FIFO of the current bank, and the bank advances at each frame boundary. With the default 32 local FIFOs, every FIFO gets exactly one slot every 32 fast cycles. The slot order never changes: a slot whose FIFO is empty is simply unused.

Each word moved into the master FIFO carries the index of its source FIFO above the local entry. Data accumulates during the beam spill. Afterwards the drain input opens a valid/ready read port on the master FIFO. If the master FIFO is full when a non-empty FIFO's slot comes up, the entry stays where it is and a sticky overflow flag is set. A done flag shows that every FIFO in the block is empty.

Top module: `rr_concentrator`

## Requirements
- R1: After reset the master FIFO and all local FIFOs are empty, `rd_valid_o` is 0, `overflow_o` is 0 and `done_o` is 1.
- R2: Count the fast cycles after reset release from 0. Cycle c serves local FIFO (c/8 mod 4)*8 + (c mod 8), which for the defaults equals c mod 32.
- R3: A master word is `{src[4:0], entry[7:0]}`. The 5-bit source index sits in bits 12:8 and the local entry in bits 7:0.
- R4: A served FIFO that is empty in its slot causes no transfer, and the slot is not given to any other FIFO.
- R5: At most one entry moves into the master FIFO per fast cycle. A given local FIFO gives up at most one entry per 32 cycles.
- R6: When the served FIFO is non-empty and the master FIFO is full, nothing moves, the entry stays at the head of its local FIFO, and `overflow_o` rises on the next cycle. It then stays 1 until reset.
- R7: `rd_valid_o` is 1 exactly when `drain_i` is 1 and the master FIFO holds data. A word is consumed on a cycle with both `rd_valid_o` and `rd_ready_i` high.
- R8: `done_o` is 1 exactly when all local FIFOs and the master FIFO are empty.
- R9: Words leave the master FIFO in the order they entered it, so entries of one local FIFO keep their push order.
- R10: A push into a local FIFO that is full (4 entries by default) at that edge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 32 | Per-local-FIFO write strobe |
| push_data_i | input | 256 | Per-local-FIFO entry, FIFO k in bits 8k+7:8k |
| drain_i | input | 1 | Enables the master read port |
| rd_ready_i | input | 1 | Reader accepts a word |
| rd_valid_o | output | 1 | Master word available |
| rd_data_o | output | 13 | Master word {source, entry} |
| overflow_o | output | 1 | Sticky master-full stall flag |
| done_o | output | 1 | All FIFOs empty |

## Verification
Several things can land on the same edge. A slot transfer into the master FIFO can coincide with a master read, and a local push can arrive on the very cycle its FIFO is served. A full master FIFO can also meet a read that frees space at that edge. The bench provokes these with drain held open and ready toggling while pushes land on chosen slots, and with a deliberate master overfill that is then drained. A scoreboard predicts each emitted word and its emission order, and checks `rd_valid_o`, `overflow_o` and `done_o` every cycle against a cycle-level model built from the requirements.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned CC_N_LOCAL = 32;
  localparam int unsigned CC_SLOTS   = 8;
  localparam int unsigned CC_ENTRY_W = 8;
  localparam int unsigned CC_LDEPTH  = 4;
  localparam int unsigned CC_MDEPTH  = 64;
endpackage

// File: rtl/cc_fifo.sv
module cc_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;   // pushes into full storage are dropped
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  p_full_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/cc_sched.sv
module cc_sched #(
  parameter int unsigned N_LOCAL = 32,
  parameter int unsigned SLOTS   = 8,
  localparam int unsigned BANKS  = N_LOCAL / SLOTS,
  localparam int unsigned IDX_W  = $clog2(N_LOCAL),
  localparam int unsigned SW     = $clog2(SLOTS),
  localparam int unsigned BW     = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] idx_o
);
  logic [SW-1:0] slot_q;
  logic [BW-1:0] bank_q;
  logic          frame_end;

  assign frame_end = (slot_q == SW'(SLOTS - 1));
  assign idx_o = IDX_W'(bank_q) * IDX_W'(SLOTS) + IDX_W'(slot_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      bank_q <= '0;
    end else begin
      slot_q <= frame_end ? '0 : slot_q + 1'b1;
      if (frame_end)
        bank_q <= (bank_q == BW'(BANKS - 1)) ? '0 : bank_q + 1'b1;
    end
  end

  p_bank_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != SW'(SLOTS - 1)) |=> (bank_q == $past(bank_q)));
  p_slot_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (slot_q == '0));
endmodule

// File: rtl/rr_concentrator.sv
module rr_concentrator
  import cc_pkg::*;
#(
  parameter int unsigned N_LOCAL = CC_N_LOCAL,
  parameter int unsigned SLOTS   = CC_SLOTS,
  parameter int unsigned ENTRY_W = CC_ENTRY_W,
  parameter int unsigned LDEPTH  = CC_LDEPTH,
  parameter int unsigned MDEPTH  = CC_MDEPTH,
  localparam int unsigned IDX_W  = $clog2(N_LOCAL),
  localparam int unsigned WORD_W = IDX_W + ENTRY_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_LOCAL-1:0]         push_i,
  input  logic [N_LOCAL*ENTRY_W-1:0] push_data_i,
  input  logic                       drain_i,
  input  logic                       rd_ready_i,
  output logic                       rd_valid_o,
  output logic [WORD_W-1:0]          rd_data_o,
  output logic                       overflow_o,
  output logic                       done_o
);
  logic [IDX_W-1:0]   idx;
  logic [N_LOCAL-1:0] local_empty, local_full, local_pop;
  logic [ENTRY_W-1:0] local_rdata [N_LOCAL];
  logic               sel_ready, xfer;
  logic               m_empty, m_full, m_pop;
  logic [WORD_W-1:0]  m_wdata;
  logic               ovf_q;

  cc_sched #(.N_LOCAL(N_LOCAL), .SLOTS(SLOTS)) u_sched (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_o (idx)
  );

  for (genvar k = 0; k < N_LOCAL; k++) begin : g_local
    assign local_pop[k] = xfer && (idx == IDX_W'(k));
    cc_fifo #(.W(ENTRY_W), .DEPTH(LDEPTH)) u_lfifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push_i[k]),
      .wdata_i(push_data_i[k*ENTRY_W +: ENTRY_W]),
      .pop_i  (local_pop[k]),
      .rdata_o(local_rdata[k]),
      .empty_o(local_empty[k]),
      .full_o (local_full[k])
    );
  end

  // slot is never reassigned: only the scheduled FIFO may move
  assign sel_ready = !local_empty[idx];
  assign xfer      = sel_ready && !m_full;
  assign m_wdata   = {idx, local_rdata[idx]};

  cc_fifo #(.W(WORD_W), .DEPTH(MDEPTH)) u_master (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (xfer),
    .wdata_i(m_wdata),
    .pop_i  (m_pop),
    .rdata_o(rd_data_o),
    .empty_o(m_empty),
    .full_o (m_full)
  );

  assign rd_valid_o = drain_i && !m_empty;
  assign m_pop      = rd_valid_o && rd_ready_i;
  assign done_o     = (&local_empty) && m_empty;
  assign overflow_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_q <= 1'b0;
    else if (sel_ready && m_full) ovf_q <= 1'b1;
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ready && m_full) |=> overflow_o);
  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  p_one_move_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(local_pop));
  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_full |-> (local_pop == '0));
  p_rd_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> drain_i);
  p_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_valid_o && (local_full == '0)));
endmodule

// File: tb/rr_concentrator_tb_top.sv
`timescale 1ns/1ps
module rr_concentrator_tb_top;
  localparam int N = 32, EW = 8, LD = 4, MD = 64, WW = 13;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N-1:0]      push = '0;
  logic [N*EW-1:0]   pdata = '0;
  logic              drain = 1'b0;
  logic              ready = 1'b0;
  logic              rd_valid, overflow, done;
  logic [WW-1:0]     rd_data;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rr_concentrator dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push), .push_data_i(pdata),
    .drain_i(drain), .rd_ready_i(ready), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .overflow_o(overflow), .done_o(done)
  );

  // reference state
  logic [EW-1:0] lbuf [N][LD];
  int            lcnt [N];
  logic [WW-1:0] exp_q [$];
  int            mcnt, cyc;
  logic          ovf_m;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic bit all_local_empty();
    for (int i = 0; i < N; i++) if (lcnt[i] != 0) return 1'b0;
    return 1'b1;
  endfunction

  // monitor / model: evaluated between edges for the coming edge
  always @(negedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) lcnt[i] = 0;
      exp_q.delete();
      mcnt = 0; cyc = 0; ovf_m = 1'b0;
    end else begin
      int  pre [N];
      int  idx;
      bit  mread, mpush;
      chk(rd_valid == (drain && mcnt > 0), "R2 R4 R5 R7 rd_valid", rd_valid, drain && mcnt > 0);
      chk(overflow == ovf_m, "R6 overflow", overflow, ovf_m);
      chk(done == (all_local_empty() && mcnt == 0), "R8 done", done, all_local_empty() && mcnt == 0);
      mread = 1'b0;
      if (rd_valid && ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected word", rd_data, 0);
        else begin
          chk(rd_data == exp_q[0], "R3 R9 R10 word", rd_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
      if (drain && mcnt > 0 && ready) mread = 1'b1;
      for (int i = 0; i < N; i++) pre[i] = lcnt[i];
      idx = ((cyc / 8) % 4) * 8 + (cyc % 8);
      mpush = 1'b0;
      if (pre[idx] > 0) begin
        if (mcnt < MD) begin
          exp_q.push_back({5'(idx), lbuf[idx][0]});
          for (int j = 0; j < LD - 1; j++) lbuf[idx][j] = lbuf[idx][j+1];
          lcnt[idx]--;
          mpush = 1'b1;
        end else ovf_m = 1'b1;
      end
      for (int i = 0; i < N; i++)
        if (push[i] && pre[i] < LD) begin
          lbuf[i][lcnt[i]] = pdata[i*EW +: EW];
          lcnt[i]++;
        end
      mcnt = mcnt + int'(mpush) - int'(mread);
      cyc++;
    end
  end

  task automatic push_one(input int k, input logic [EW-1:0] v);
    @(posedge clk); #1;
    push = '0; push[k] = 1'b1; pdata[k*EW +: EW] = v;
    @(posedge clk); #1;
    push = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    #1 rst_ni = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    chk(done == 1'b1,     "R1 done", done, 1);
    rst_ni = 1'b1;

    // single words with drain open: tag layout and slot timing
    @(posedge clk); #1 drain = 1'b1; ready = 1'b1;
    push_one(17, 8'hA5);
    push_one(5, 8'h11);
    push_one(6, 8'h22);   // FIFO 6 must wait for its own slot
    idle(70);

    // bursts into one FIFO, including a dropped push beyond depth
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) begin
      push = '0; push[2] = 1'b1; push[9] = 1'b1;
      pdata[2*EW +: EW] = 8'h20 + 8'(i);
      pdata[9*EW +: EW] = 8'h90 + 8'(i);
      @(posedge clk); #1;
    end
    push = '0;
    idle(260);

    // backpressure while transfers run
    for (int i = 0; i < 8; i++) push_one((i * 7) % N, 8'hC0 + 8'(i));
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1 ready = (i % 3) != 0;
    end
    ready = 1'b1;
    idle(40);

    // overfill master with drain closed, then drain
    @(posedge clk); #1 drain = 1'b0;
    for (int r = 0; r < LD; r++) begin
      push = '1;
      for (int i = 0; i < N; i++) pdata[i*EW +: EW] = 8'(r * 64 + i);
      @(posedge clk); #1;
    end
    push = '0;
    idle(200);
    @(negedge clk);
    chk(overflow == 1'b1, "R6 overflow after overfill", overflow, 1);
    chk(rd_valid == 1'b0, "R7 held while drain low", rd_valid, 0);
    @(posedge clk); #1 drain = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #1 ready = (i % 5) != 2;
    end
    ready = 1'b1;
    idle(200);
    @(negedge clk);
    chk(done == 1'b1, "R8 done at end", done, 1);
    chk(exp_q.size() == 0, "R9 all words emitted", exp_q.size(), 0);
    chk(overflow == 1'b1, "R6 sticky", overflow, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule